// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

This block is one timer channel that turns a single up-counter and four compare values into pulse-width-modulated outputs. Each compare value has its own small control word. The word holds a match action (hold, drive low, drive high or toggle) and the level the pin takes when the channel starts. The counter advances only on cycles where the prescaled count enable is high and the channel has been started.

Two ways of using the compare values are offered. In paired mode, compare values 0 and 1 together shape pin 0, and values 2 and 3 together shape pin 2. One match sets the leading edge and the other sets the trailing edge. In cycle/duty mode, the compare value chosen as the clear source fixes the period. Every other compare value becomes a duty threshold for its own pin, and at each period boundary all duty pins return to their start levels. Software programs the block through a flat register write port.

Top module: `pwm_timer`

## Requirements
- R1: After synchronous reset, all four pins are low and the channel is stopped.
- R2: The counter advances and match actions apply only on a clock where the channel is started and `cnt_en` is high. Otherwise the pins keep their levels. Writing 0 to the start bit stops the channel.
- R3: Write addresses 0 to 3 load compare value k. Addresses 4 to 7 load the control word of compare k, with bits [1:0] as the action (00 hold, 01 low, 10 high, 11 toggle) and bit 2 as the start level. Address 8 is the mode word: bit 0 selects the mode (0 paired, 1 cycle/duty), bits [2:1] select the clear source, bit 3 enables clearing in paired mode, and bit 4 is the start bit.
- R4: On a counting clock where the counter equals the clear-source compare value and clearing is active, the counter goes to 0. Otherwise it goes up by one. With clearing off, it wraps from all ones to 0. Clearing is always active in cycle/duty mode.
- R5: In paired mode, a match on compare 0 applies action 0 to pin 0, and a match on compare 1 applies action 1 to pin 0. Compares 2 and 3 drive pin 2 the same way. Pins 1 and 3 are low.
- R6: In paired mode, when the two compare values of a pair are equal, their matches leave that pin unchanged.
- R7: A 0-to-1 write of the start bit resets the counter to 0 one clock later and loads start levels in that same clock. In paired mode, pins 0 and 2 take the start level of compare 0 and compare 2. In cycle/duty mode, each duty pin takes its own start level. The first count happens on the clock after that.
- R8: In cycle/duty mode, the period is the clear-source value plus one count. The pin with the clear-source index stays low. Every other pin follows its own match action and returns to its start level at the period boundary.
- R9: In cycle/duty mode, a duty value equal to or above the period value never changes the pin, so its start level gives 0% or 100% duty. Lower values give intermediate duties down to one count.
- R10: When the period match and a duty match land on the same count, the return to the start level wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0-3 compare, 4-7 control, 8 mode) |
| wr_data | input | CNT_W | Write data |
| cnt_en | input | 1 | Prescaled count enable |
| pin_out | output | 4 | PWM output pins, bit k belongs to compare k |

## Verification
The bench builds the channel with a 6-bit counter. This keeps the all-ones wrap within about a hundred clocks and still leaves room for several period lengths. It sweeps every duty and leading-edge value from 0 to one past the period, for several periods in both modes. These sweeps reach the 0% and 100% ends, the equal-value suppression and the coincident period/duty match. A gated count-enable pattern, a stop in the middle of a run and a restart cover the enable and reload behaviour.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    localparam int NCMP   = 4;
    localparam int ADDR_W = 4;
    localparam int CTL_W  = 5;
    localparam logic [ADDR_W-1:0] ADDR_CFG0 = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 4'd8;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;

    typedef enum logic {
        MODE_PAIR = 1'b0,
        MODE_DUTY = 1'b1
    } mode_e;

    typedef struct packed {
        logic init;
        act_e act;
    } pin_cfg_t;

    typedef struct packed {
        logic       start;
        logic       clr_en;
        logic [1:0] clr_sel;
        mode_e      mode;
    } ctl_t;

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_TOG:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [CNT_W-1:0]                  wr_data,
    output logic [NCMP-1:0][CNT_W-1:0]        cmp,
    output pin_cfg_t [NCMP-1:0]               pcfg,
    output ctl_t                              ctl,
    output logic                              start_pulse
);

    for (genvar k = 0; k < NCMP; k++) begin : g_reg
        localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(k);
        localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_CFG0 + ADDR_W'(k);

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[k]  <= '0;
                pcfg[k] <= '0;
            end else if (wr_en) begin
                if (wr_addr == CMP_ADDR) cmp[k]  <= wr_data;
                if (wr_addr == CFG_ADDR) pcfg[k] <= pin_cfg_t'(wr_data[2:0]);
            end
        end
    end

    logic mode_wr;
    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl         <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= mode_wr && wr_data[CTL_W-1] && !ctl.start;
            if (mode_wr) ctl <= ctl_t'(wr_data[CTL_W-1:0]);
        end
    end

    assert_pulse_running_R7: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> ctl.start);

endmodule

// File: rtl/pwm_up_counter.sv
module pwm_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_zero,
    input  logic             clr_active,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             clr_hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign clr_hit = clr_active && (cnt == period);

    always_ff @(posedge clk) begin
        if (rst || load_zero) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= clr_hit ? '0 : cnt + 1'b1;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_zero) |=> $stable(cnt));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_hit) |=> (cnt == '0));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr_active && !load_zero && cnt == CNT_MAX) |=> (cnt == '0));

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        load_zero |=> (cnt == '0));

endmodule

// File: rtl/pwm_pin_logic.sv
module pwm_pin_logic
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       start_pulse,
    input  ctl_t                       ctl,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp,
    input  pin_cfg_t [NCMP-1:0]        pcfg,
    input  logic [CNT_W-1:0]           cnt,
    input  logic                       clr_hit,
    output logic [NCMP-1:0]            lvl
);

    logic [NCMP-1:0] hit;
    logic [NCMP-1:0] nxt;

    for (genvar k = 0; k < NCMP; k++) begin : g_pin
        localparam int         PART  = k ^ 1;
        localparam bit         EVEN  = ((k % 2) == 0);
        localparam logic [1:0] IDX   = 2'(k);

        assign hit[k] = tick && (cnt == cmp[k]);

        always_comb begin
            nxt[k] = lvl[k];
            if (start_pulse) begin
                if (ctl.mode == MODE_DUTY)
                    nxt[k] = (ctl.clr_sel == IDX) ? 1'b0 : pcfg[k].init;
                else
                    nxt[k] = EVEN ? pcfg[k].init : 1'b0;
            end else if (tick) begin
                if (ctl.mode == MODE_DUTY) begin
                    if (ctl.clr_sel == IDX)
                        nxt[k] = 1'b0;
                    else if (clr_hit)
                        nxt[k] = pcfg[k].init;
                    else if (hit[k])
                        nxt[k] = apply_act(pcfg[k].act, lvl[k]);
                end else if (EVEN) begin
                    if (cmp[k] != cmp[PART]) begin
                        if (hit[k])
                            nxt[k] = apply_act(pcfg[k].act, lvl[k]);
                        else if (hit[PART])
                            nxt[k] = apply_act(pcfg[PART].act, lvl[k]);
                    end
                end else begin
                    nxt[k] = 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) lvl[k] <= 1'b0;
            else     lvl[k] <= nxt[k];
        end

        assert_cycle_return_R10: assert property (@(posedge clk) disable iff (rst)
            (tick && !start_pulse && ctl.mode == MODE_DUTY && clr_hit && ctl.clr_sel != IDX)
            |=> (lvl[k] == $past(pcfg[k].init)));
    end

    assert_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start_pulse) |=> $stable(lvl));

    assert_pair_equal_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !start_pulse && ctl.mode == MODE_PAIR && cmp[0] == cmp[1])
        |=> (lvl[0] == $past(lvl[0])));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              cnt_en,
    output logic [3:0]        pin_out
);

    logic [NCMP-1:0][CNT_W-1:0] cmp;
    pin_cfg_t [NCMP-1:0]        pcfg;
    ctl_t                       ctl;
    logic                       start_pulse;
    logic [CNT_W-1:0]           cnt;
    logic                       clr_hit;
    logic                       tick;
    logic                       clr_active;
    logic [NCMP-1:0]            lvl;

    assign tick       = ctl.start && cnt_en && !start_pulse;
    assign clr_active = (ctl.mode == MODE_DUTY) || ctl.clr_en;

    pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cmp         (cmp),
        .pcfg        (pcfg),
        .ctl         (ctl),
        .start_pulse (start_pulse)
    );

    pwm_up_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load_zero  (start_pulse),
        .clr_active (clr_active),
        .period     (cmp[ctl.clr_sel]),
        .cnt        (cnt),
        .clr_hit    (clr_hit)
    );

    pwm_pin_logic #(.CNT_W(CNT_W)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start_pulse (start_pulse),
        .ctl         (ctl),
        .cmp         (cmp),
        .pcfg        (pcfg),
        .cnt         (cnt),
        .clr_hit     (clr_hit),
        .lvl         (lvl)
    );

    assign pin_out = lvl;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (pin_out == 4'b0000 && !ctl.start));

endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

    localparam int W    = 6;
    localparam int WRAP = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         cnt_en = 1'b0;
    logic [3:0]   pin_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwm_timer #(.CNT_W(W)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt_en  (cnt_en),
        .pin_out (pin_out)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = W'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R3: control word {start level, action[1:0]} at 4+k
    task automatic cfg(input int k, input int v, input int init, input int act);
        wr(k, v);
        wr(4 + k, (init << 2) | act);
    endtask

    // R3: mode word {start, clr_en, clr_sel[1:0], mode}
    task automatic stop_ch();
        wr(8, 0);
    endtask

    task automatic start_ch(input int mode, input int sel, input int clr_en);
        cnt_en = 1'b0;
        wr(8, (clr_en << 3) | (sel << 1) | mode);
        wr(8, 16 | (clr_en << 3) | (sel << 1) | mode);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Duty scenario: pin0 start 1 act low at dA, pin1 start 0 toggle at P-1,
    // pin2 start 1 hold at 0, pin3 is the cycle register (low).
    function automatic logic [3:0] exp_duty(input int p, input int da, input int t);
        int c;
        logic a, b;
        if (t == 0) return 4'b0101;
        c = (t - 1) % (p + 1);
        a = (da >= p) ? 1'b1 : ((c < da) || (c == p));
        b = (c == p - 1);
        return {1'b0, 1'b1, b, a};
    endfunction

    // Paired scenario: pin0 start 0, act high at a, act low at P (compare 1, clear source);
    // pin2 start 1 with equal compares 2 and 3 (both toggle).
    function automatic logic [3:0] exp_pair(input int p, input int a, input int t);
        int c;
        logic pa;
        if (t == 0) return 4'b0100;
        c  = (t - 1) % (p + 1);
        pa = (a < p) && (c >= a) && (c < p);
        return {1'b0, 1'b1, 1'b0, pa};
    endfunction

    function automatic logic [3:0] exp_wrap(input int t);
        if (t == 0) return 4'b0000;
        return {3'b000, 1'(((t - 1) / WRAP + 1) & 1)};
    endfunction

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int p_list[3];
        logic [3:0] held;
        p_list = '{2, 5, 9};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset pins", pin_out, 4'b0000);

        // R8 R9 R10 R3: duty sweep, compare 3 is the cycle register
        foreach (p_list[pi]) begin
            for (int da = 0; da <= p_list[pi] + 1; da++) begin
                int t;
                stop_ch();
                cfg(0, da, 1, 1);
                cfg(1, p_list[pi] - 1, 0, 3);
                cfg(2, 0, 1, 0);
                cfg(3, p_list[pi], 0, 3);
                start_ch(1, 3, 0);
                chk("R7 duty start levels", pin_out, 4'b0101);
                t = 0;
                for (int i = 0; i < 2 * (p_list[pi] + 1) + 2; i++) begin
                    cnt_en = 1'b1;
                    @(posedge clk);
                    t++;
                    @(negedge clk);
                    chk("R8 R9 R10 duty waveform", pin_out, exp_duty(p_list[pi], da, t));
                end
            end
        end

        // R2: gated enable, then stop with enable held high
        begin
            int t;
            stop_ch();
            cfg(0, 2, 1, 1);
            cfg(1, 4, 0, 3);
            cfg(2, 0, 1, 0);
            cfg(3, 5, 0, 3);
            start_ch(1, 3, 0);
            t = 0;
            for (int i = 0; i < 30; i++) begin
                cnt_en = (i % 3) != 0;
                @(posedge clk);
                if (cnt_en) t++;
                @(negedge clk);
                chk("R2 gated count enable", pin_out, exp_duty(5, 2, t));
            end
            cnt_en = 1'b1;
            stop_ch();
            held = pin_out;
            for (int i = 0; i < 10; i++) begin
                @(posedge clk);
                @(negedge clk);
                chk("R2 stopped pins hold", pin_out, held);
            end
            start_ch(1, 3, 0);
            chk("R7 restart reloads start levels", pin_out, 4'b0101);
        end

        // R5 R6 R4: paired sweep, compare 1 is the clear source
        for (int pp = 4; pp <= 7; pp += 3) begin
            for (int a = 0; a <= pp + 1; a++) begin
                int t;
                stop_ch();
                cfg(0, a, 0, 2);
                cfg(1, pp, 0, 1);
                cfg(2, 2, 1, 3);
                cfg(3, 2, 0, 3);
                start_ch(0, 1, 1);
                chk("R7 paired start levels", pin_out, 4'b0100);
                t = 0;
                for (int i = 0; i < 2 * (pp + 1) + 2; i++) begin
                    cnt_en = 1'b1;
                    @(posedge clk);
                    t++;
                    @(negedge clk);
                    chk("R5 R6 R4 paired waveform", pin_out, exp_pair(pp, a, t));
                end
            end
        end

        // R4: no clear source, counter wraps at all ones
        begin
            int t;
            stop_ch();
            cfg(0, 0, 0, 3);
            cfg(1, 9, 0, 0);
            cfg(2, 3, 0, 0);
            cfg(3, 5, 0, 0);
            start_ch(0, 1, 0);
            t = 0;
            for (int i = 0; i < 2 * WRAP + 10; i++) begin
                cnt_en = 1'b1;
                @(posedge clk);
                t++;
                @(negedge clk);
                chk("R4 wrap at all ones", pin_out, exp_wrap(t));
            end
        end

        cnt_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule